// File: doc/BRIEF.md
# NAND Page-Streaming Read Engine

This block is the device side of a NAND-style flash read path. It provides a read mode that streams across page boundaries. A host writes a command byte while the command-latch enable is high. It then writes three address bytes while the address-latch enable is high, each byte captured on a rising edge of the write strobe. The engine then drives its ready/busy output low while it copies the addressed page from an internal array into a page buffer. After that, every falling edge of the read strobe presents one byte and moves the column forward by one. At the end of a page the stream continues into the next page with no second busy interval, because a second buffer is filled in the background while the current page is read out.

A page holds 528 bytes: a 512-byte main area followed by a 16-byte spare area. The spare-area enable input sets the last column before the page changes. When it is high the stream skips the spare bytes; when it is low they are read. The array has a parameterized, power-of-two page count, and its contents are computed from the page and column. The busy time is a parameter of at least 2 cycles. A status command, a reset command and an abort on chip-enable movement during busy complete the interface. All pins are sampled synchronously to `clk`.

Top module: `nand_stream_engine`

## Requirements
- R1: Opcode 0x02 on a command cycle (cmdLatchEn=1, addrLatchEn=0, ceN=0), followed by three address cycles (addrLatchEn=1), starts a read. The first address byte is column[7:0], bit 0 of the second is column[8], and the low bits of the third are the page. The first byte streamed is the one at that start column and page.
- R2: A start column of 256 or higher (second-address bit 0 set) is rejected. addrErr goes high and readyBusyN never goes low.
- R3: readyBusyN is low for exactly BUSY_CYCLES clock cycles after an accepted start, provided BUSY_CYCLES exceeds the page length plus two.
- R4: In streaming, each read-strobe falling edge outputs the array byte ((column*3) + (page*37) + (column>>8)) mod 256 on dataOut, then advances the column by one.
- R5: With spareEnN high, the byte after column 511 is column 0 of page+1. The page number wraps to 0 after the last page.
- R6: With spareEnN low, the columns run through 512..527 before moving to column 0 of page+1.
- R7: readyBusyN stays high at every page crossing of a stream.
- R8: While busy, any command other than 0xFF and 0x70 is ignored. A repeated 0x02 changes neither the busy length nor the start column.
- R9: After command 0x70, each read-strobe falling edge outputs a status byte. Bit 6 is 1 when ready, bit 0 is the rejection flag, and the other bits are 0.
- R10: Command 0xFF returns the engine to idle from any state. It clears addrErr and status mode, and later read strobes leave dataOut unchanged.
- R11: A change of ceN while busy aborts the read, and readyBusyN is high on the next cycle.
- R12: addrLatchEn falling after one or two address bytes discards them. Further address cycles start nothing until 0x02 is issued again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Chip enable, active low |
| cmdLatchEn | input | 1 | Command latch enable |
| addrLatchEn | input | 1 | Address latch enable |
| weN | input | 1 | Write strobe, captured on its rising edge |
| reN | input | 1 | Read strobe, acts on its falling edge |
| spareEnN | input | 1 | Low: stream includes the spare area |
| dataIn | input | 8 | Command and address byte |
| dataOut | output | 8 | Streamed data or status byte |
| readyBusyN | output | 1 | Low while a page is being loaded |
| addrErr | output | 1 | Start column was rejected |

## Verification
readyBusyN falls on the first clock edge after the third address strobe rises. addrErr and the return to idle after 0xFF or a ceN change also appear one edge after the strobe or pin change is sampled. A read or status byte reaches dataOut two edges after the read strobe is seen low: one edge registers the strobe, the next loads the output. Each bench task therefore holds reN low for two full cycles and samples at the falling clock edge after the second one. The busy length is counted on rising edges using the value of readyBusyN from before the edge, so the count is exact and free of ordering races.

// File: rtl/nand_stream_pkg.sv
package nand_stream_pkg;
  localparam int PAGE_BYTES = 528;
  localparam int MAIN_BYTES = 512;
  localparam int COL_W      = 10;

  localparam logic [7:0] OP_STREAM = 8'h02;
  localparam logic [7:0] OP_STATUS = 8'h70;
  localparam logic [7:0] OP_RESET  = 8'hFF;

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_BUSY, S_STREAM} eng_state_t;

  typedef struct packed {
    logic start;
    logic advance;
    logic showStatus;
    logic abort;
  } strobe_t;

  function automatic logic [7:0] cellValue(input logic [7:0] page, input logic [COL_W-1:0] col);
    logic [COL_W-1:0] scaled;
    scaled = col * 10'd3;
    return scaled[7:0] + 8'(page * 8'd37) + 8'(col >> 8);
  endfunction
endpackage

// File: rtl/nand_stream_ctrl.sv
module nand_stream_ctrl
  import nand_stream_pkg::*;
#(
  parameter int BUSY_CYCLES = 600,
  parameter int PAGE_W      = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              cmdLatchEn,
  input  logic              addrLatchEn,
  input  logic              weN,
  input  logic              reN,
  input  logic [7:0]        dataIn,
  input  logic              firstLoaded,
  output strobe_t           strb,
  output logic [COL_W-1:0]  startCol,
  output logic [PAGE_W-1:0] startPage,
  output logic              ryBy,
  output logic              errFlag,
  output logic [7:0]        statusByte
);
  localparam int BUSY_CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [BUSY_CNT_W-1:0] BUSY_LAST = BUSY_CNT_W'(BUSY_CYCLES - 1);

  eng_state_t state;
  logic wePrev, rePrev, cePrev;
  logic [1:0] addrCnt;
  logic [7:0] addrLow;
  logic addrHalf;
  logic statusMode;
  logic [BUSY_CNT_W-1:0] busyCnt;

  logic weRise, reFall, ceEdge, cmdLatch, addrLatch, busyDone;
  assign weRise    = ~wePrev & weN;
  assign reFall    = rePrev & ~reN;
  assign ceEdge    = cePrev ^ ceN;
  assign cmdLatch  = weRise & cmdLatchEn & ~addrLatchEn & ~ceN;
  assign addrLatch = weRise & addrLatchEn & ~cmdLatchEn & ~ceN;
  assign busyDone  = busyCnt >= BUSY_LAST;

  assign ryBy       = (state != S_BUSY);
  assign statusByte = {1'b0, ryBy, 5'b0, errFlag};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      wePrev     <= 1'b1;
      rePrev     <= 1'b1;
      cePrev     <= 1'b1;
      addrCnt    <= '0;
      addrLow    <= '0;
      addrHalf   <= 1'b0;
      statusMode <= 1'b0;
      errFlag    <= 1'b0;
      busyCnt    <= '0;
      startCol   <= '0;
      startPage  <= '0;
      strb       <= '0;
    end else begin
      wePrev <= weN;
      rePrev <= reN;
      cePrev <= ceN;
      strb   <= '0;

      if (state == S_BUSY && !busyDone) busyCnt <= busyCnt + 1'b1;
      if (state == S_BUSY && busyDone && firstLoaded) state <= S_STREAM;

      if (state == S_STREAM && reFall && !statusMode) strb.advance <= 1'b1;
      if (reFall && statusMode) strb.showStatus <= 1'b1;

      // partial address is dropped as soon as the address latch falls
      if (state == S_ADDR && addrCnt != 2'd0 && !addrLatchEn) state <= S_IDLE;

      if (state == S_ADDR && addrLatch) begin
        case (addrCnt)
          2'd0: begin addrLow <= dataIn; addrCnt <= 2'd1; end
          2'd1: begin addrHalf <= dataIn[0]; addrCnt <= 2'd2; end
          default: begin
            addrCnt   <= 2'd0;
            startCol  <= {addrHalf, addrLow};
            startPage <= dataIn[PAGE_W-1:0];
            if (addrHalf) begin
              errFlag <= 1'b1;
              state   <= S_IDLE;
            end else begin
              state      <= S_BUSY;
              busyCnt    <= '0;
              strb.start <= 1'b1;
            end
          end
        endcase
      end

      if (cmdLatch) begin
        if (dataIn == OP_STREAM && state != S_BUSY) begin
          state      <= S_ADDR;
          addrCnt    <= 2'd0;
          statusMode <= 1'b0;
          errFlag    <= 1'b0;
        end
        if (dataIn == OP_STATUS) statusMode <= 1'b1;
      end

      if (state == S_BUSY && ceEdge) begin
        state      <= S_IDLE;
        strb.abort <= 1'b1;
      end

      if (cmdLatch && dataIn == OP_RESET) begin
        state      <= S_IDLE;
        addrCnt    <= 2'd0;
        statusMode <= 1'b0;
        errFlag    <= 1'b0;
        strb.abort <= 1'b1;
      end
    end
  end

  p_busy_len_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_BUSY && !busyDone) |=> (state != S_STREAM));

  p_reject_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ADDR && addrLatch && addrCnt == 2'd2 && addrHalf) |=> (ryBy && errFlag));

  p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_BUSY && cmdLatch && dataIn != OP_RESET && !ceEdge)
      |=> (state == S_BUSY || state == S_STREAM));

  p_reset_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cmdLatch && dataIn == OP_RESET) |=> (state == S_IDLE && !errFlag && !statusMode));

  p_ce_abort_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_BUSY && ceEdge) |=> ryBy);
endmodule

// File: rtl/nand_stream_dp.sv
module nand_stream_dp
  import nand_stream_pkg::*;
#(
  parameter int PAGE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [COL_W-1:0]  startCol,
  input  logic [PAGE_W-1:0] startPage,
  input  logic              spareEnN,
  input  logic [7:0]        statusByte,
  output logic [7:0]        dataOut,
  output logic              firstLoaded
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(PAGE_BYTES - 1);
  localparam logic [COL_W-1:0] MAIN_END = COL_W'(MAIN_BYTES - 1);

  logic [7:0] bufMem [2][PAGE_BYTES];

  logic              rdSel, fillSel, fillActive, pendNext;
  logic [COL_W-1:0]  col, fillCol;
  logic [PAGE_W-1:0] page, fillPage;
  logic [COL_W-1:0]  lastCol;
  logic              atEnd;

  assign lastCol = spareEnN ? MAIN_END : LAST_COL;
  assign atEnd   = col >= lastCol;

  always_ff @(posedge clk) begin
    if (fillActive) bufMem[fillSel][fillCol] <= cellValue(8'(fillPage), fillCol);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdSel       <= 1'b0;
      fillSel     <= 1'b0;
      fillActive  <= 1'b0;
      pendNext    <= 1'b0;
      col         <= '0;
      fillCol     <= '0;
      page        <= '0;
      fillPage    <= '0;
      dataOut     <= '0;
      firstLoaded <= 1'b0;
    end else begin
      if (fillActive) begin
        if (fillCol == LAST_COL) begin
          fillActive  <= 1'b0;
          firstLoaded <= 1'b1;
        end else begin
          fillCol <= fillCol + 1'b1;
        end
      end else if (pendNext) begin
        fillActive <= 1'b1;
        fillSel    <= ~rdSel;
        fillPage   <= page + PAGE_W'(1);
        fillCol    <= '0;
        pendNext   <= 1'b0;
      end

      if (strb.advance) begin
        dataOut <= bufMem[rdSel][col];
        if (atEnd) begin
          col      <= '0;
          rdSel    <= ~rdSel;
          page     <= page + PAGE_W'(1);
          pendNext <= 1'b1;
        end else begin
          col <= col + 1'b1;
        end
      end

      if (strb.showStatus) dataOut <= statusByte;

      if (strb.start) begin
        col         <= startCol;
        page        <= startPage;
        rdSel       <= 1'b0;
        fillActive  <= 1'b1;
        fillSel     <= 1'b0;
        fillPage    <= startPage;
        fillCol     <= '0;
        pendNext    <= 1'b1;
        firstLoaded <= 1'b0;
      end

      if (strb.abort) begin
        fillActive  <= 1'b0;
        pendNext    <= 1'b0;
        firstLoaded <= 1'b0;
      end
    end
  end

  p_refill_ready_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && atEnd) |-> (!fillActive && !pendNext));

  p_col_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    col <= LAST_COL);
endmodule

// File: rtl/nand_stream_engine.sv
module nand_stream_engine
  import nand_stream_pkg::*;
#(
  parameter int NUM_PAGES   = 4,
  parameter int BUSY_CYCLES = 600
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       cmdLatchEn,
  input  logic       addrLatchEn,
  input  logic       weN,
  input  logic       reN,
  input  logic       spareEnN,
  input  logic [7:0] dataIn,
  output logic [7:0] dataOut,
  output logic       readyBusyN,
  output logic       addrErr
);
  localparam int PAGE_W = $clog2(NUM_PAGES);

  strobe_t           strb;
  logic [COL_W-1:0]  startCol;
  logic [PAGE_W-1:0] startPage;
  logic              firstLoaded;
  logic [7:0]        statusByte;

  nand_stream_ctrl #(.BUSY_CYCLES(BUSY_CYCLES), .PAGE_W(PAGE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .cmdLatchEn(cmdLatchEn),
    .addrLatchEn(addrLatchEn), .weN(weN), .reN(reN), .dataIn(dataIn),
    .firstLoaded(firstLoaded), .strb(strb), .startCol(startCol),
    .startPage(startPage), .ryBy(readyBusyN), .errFlag(addrErr),
    .statusByte(statusByte)
  );

  nand_stream_dp #(.PAGE_W(PAGE_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .startCol(startCol),
    .startPage(startPage), .spareEnN(spareEnN), .statusByte(statusByte),
    .dataOut(dataOut), .firstLoaded(firstLoaded)
  );
endmodule

// File: tb/sim_nand_stream_engine.sv
`timescale 1ns/1ps
module sim_nand_stream_engine;
  localparam int BUSY = 600;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b0, cmdLatchEn = 1'b0, addrLatchEn = 1'b0;
  logic weN = 1'b1, reN = 1'b1, spareEnN = 1'b1;
  logic [7:0] dataIn = 8'h00;
  logic [7:0] dataOut;
  logic readyBusyN, addrErr;

  int tests = 0;
  int fails = 0;
  int lowCnt = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  nand_stream_engine #(.NUM_PAGES(4), .BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rstN(rstN), .ceN(ceN), .cmdLatchEn(cmdLatchEn),
    .addrLatchEn(addrLatchEn), .weN(weN), .reN(reN), .spareEnN(spareEnN),
    .dataIn(dataIn), .dataOut(dataOut), .readyBusyN(readyBusyN), .addrErr(addrErr)
  );

  always @(posedge clk) if (readyBusyN === 1'b0) lowCnt++;

  function automatic logic [7:0] expByte(input int page, input int col);
    return 8'((col * 3 + page * 37 + (col >> 8)) & 255);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendCmd(input logic [7:0] b);
    @(negedge clk); cmdLatchEn = 1'b1; addrLatchEn = 1'b0; dataIn = b; weN = 1'b0;
    @(negedge clk); weN = 1'b1;
    @(negedge clk); cmdLatchEn = 1'b0;
  endtask

  task automatic sendAddr(input logic [7:0] b);
    @(negedge clk); addrLatchEn = 1'b1; dataIn = b; weN = 1'b0;
    @(negedge clk); weN = 1'b1;
    @(negedge clk);
  endtask

  task automatic startRead(input int col, input int page);
    sendCmd(8'h02);
    sendAddr(8'(col & 255));
    sendAddr(8'((col >> 8) & 1));
    sendAddr(8'(page));
    addrLatchEn = 1'b0;
  endtask

  task automatic pulseRead(output logic [7:0] v);
    @(negedge clk); reN = 1'b0;
    @(negedge clk);
    @(negedge clk); v = dataOut; reN = 1'b1;
  endtask

  task automatic waitReady();
    while (readyBusyN !== 1'b1) @(negedge clk);
  endtask

  task automatic testReset();
    chk("R10 reset ready", 32'(readyBusyN), 1);
    chk("R10 reset err", 32'(addrErr), 0);
    chk("R10 reset data", 32'(dataOut), 0);
  endtask

  task automatic testMainStream();
    int base, bad, busyHigh;
    logic [7:0] v;
    spareEnN = 1'b1;
    base = lowCnt;
    startRead(250, 1);
    waitReady();
    chk("R3 busy length", 32'(lowCnt - base), 32'(BUSY));
    bad = 0; busyHigh = 0;
    for (int c = 250; c < 512; c++) begin
      pulseRead(v);
      if (c == 250) chk("R1 first byte", 32'(v), 32'(expByte(1, 250)));
      if (c == 511) chk("R5 last main byte", 32'(v), 32'(expByte(1, 511)));
      if (v !== expByte(1, c)) bad++;
    end
    for (int c = 0; c < 4; c++) begin
      pulseRead(v);
      if (c == 0) chk("R5 next page col0", 32'(v), 32'(expByte(2, 0)));
      if (v !== expByte(2, c)) bad++;
      if (readyBusyN !== 1'b1) busyHigh++;
    end
    chk("R4 stream bytes", 32'(bad), 0);
    chk("R7 no busy at crossing", 32'(busyHigh + (lowCnt - base - BUSY)), 0);
  endtask

  task automatic testSpareStream();
    int base, bad;
    logic [7:0] v;
    spareEnN = 1'b0;
    base = lowCnt;
    startRead(200, 3);
    waitReady();
    bad = 0;
    for (int c = 200; c < 528; c++) begin
      pulseRead(v);
      if (c == 512) chk("R6 first spare byte", 32'(v), 32'(expByte(3, 512)));
      if (c == 527) chk("R6 last spare byte", 32'(v), 32'(expByte(3, 527)));
      if (v !== expByte(3, c)) bad++;
    end
    pulseRead(v);
    chk("R5 wrap to page 0", 32'(v), 32'(expByte(0, 0)));
    chk("R6 spare stream bytes", 32'(bad), 0);
    chk("R7 single busy period", 32'(lowCnt - base), 32'(BUSY));
    spareEnN = 1'b1;
  endtask

  task automatic testReject();
    int base;
    logic [7:0] v;
    base = lowCnt;
    startRead(300, 0);
    repeat (5) @(negedge clk);
    chk("R2 error flag", 32'(addrErr), 1);
    chk("R2 no busy", 32'(lowCnt - base), 0);
    sendCmd(8'h70);
    pulseRead(v);
    chk("R9 status after reject", 32'(v), 32'h41);
  endtask

  task automatic testIgnoreBusy();
    int base;
    logic [7:0] v;
    sendCmd(8'hFF);
    chk("R10 reset clears err", 32'(addrErr), 0);
    base = lowCnt;
    startRead(10, 2);
    repeat (20) @(negedge clk);
    sendCmd(8'h02);
    sendCmd(8'h80);
    chk("R8 still busy", 32'(readyBusyN), 0);
    waitReady();
    chk("R8 busy length kept", 32'(lowCnt - base), 32'(BUSY));
    pulseRead(v);
    chk("R8 start column kept", 32'(v), 32'(expByte(2, 10)));
  endtask

  task automatic testStatusBusy();
    logic [7:0] v;
    startRead(0, 0);
    sendCmd(8'h70);
    pulseRead(v);
    chk("R9 status while busy", 32'(v), 32'h00);
    waitReady();
    pulseRead(v);
    chk("R9 status when ready", 32'(v), 32'h40);
    sendCmd(8'hFF);
    chk("R10 ready after reset", 32'(readyBusyN), 1);
    pulseRead(v);
    chk("R10 data held after reset", 32'(v), 32'h40);
  endtask

  task automatic testCeAbort();
    int base;
    base = lowCnt;
    startRead(5, 1);
    repeat (50) @(negedge clk);
    ceN = 1'b1;
    @(negedge clk);
    chk("R11 abort ready", 32'(readyBusyN), 1);
    chk("R11 busy cut short", 32'((lowCnt - base) < BUSY), 1);
    ceN = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic testAleDrop();
    int base;
    logic [7:0] v;
    base = lowCnt;
    sendCmd(8'h02);
    sendAddr(8'd7);
    @(negedge clk); addrLatchEn = 1'b0;
    @(negedge clk);
    sendAddr(8'd0);
    sendAddr(8'd1);
    addrLatchEn = 1'b0;
    repeat (20) @(negedge clk);
    chk("R12 discarded address no busy", 32'(lowCnt - base), 0);
    chk("R12 discarded address no err", 32'(addrErr), 0);
    startRead(7, 1);
    waitReady();
    pulseRead(v);
    chk("R12 fresh read works", 32'(v), 32'(expByte(1, 7)));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMainStream();
    testSpareStream();
    testReject();
    testIgnoreBusy();
    testStatusBusy();
    testCeAbort();
    testAleDrop();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule